// File: doc/BRIEF.md
# Conditional Branch and Call Sequencer

This block is the program counter unit of a small 16-bit-word processor. Every cycle it presents the fetch address of the current instruction word. The surrounding fetch logic returns that word together with the word that follows it. The sequencer decodes both words, evaluates any condition against the zero and less-or-equal flags, and chooses the next fetch address. That address is one of: the next word; the word after a trailing parameter word; an absolute target carried in the parameter word; the saved return address; or a signed 8-bit displacement from the current instruction.

It also reports whether the current instruction consumes the parameter word. Calls save the address of the word after the two-word call in one return register, which holds a single level. A stall input freezes all state.

Top module: `branch_seq_top`

## Requirements
- R1: A clock edge with rst_n low sets both the fetch address and the return register to 0x0000.
- R2: While stall is high, neither the fetch address nor the return register changes, whatever the instruction.
- R3: A word that is not one of the two-word forms and not a branch or return advances the fetch address by 1, with param_used low. This includes a branch or return whose bit 0 is 1.
- R4: A two-word non-branch word raises param_used and advances the fetch address by 2. There are two such forms: a 16-bit immediate operation (bits 15..6 = 1110000000) and a register-bus load/store (bits 15..2 = 11100000110000).
- R5: The condition field sits in bits 3..1. The value 001 holds when le is high, 100 when z is low, 101 when z is high, and 111 always. Every other value never holds.
- R6: An absolute branch has bits 15..6 = 1110010000, bit 5 = 0 and bit 0 = 0. It always raises param_used. If its condition holds, the next address is the parameter word; otherwise it is the current address + 2.
- R7: An absolute branch with bit 4 = 1 is a call. A taken call loads the return register with the current address + 2, overwriting any earlier value. Every other instruction, including a taken jump with bit 4 = 0, leaves the return register unchanged.
- R8: A return has bits 15..4 = 111001000010 and bit 0 = 0. If its condition holds, the next address is the return register; otherwise it is the current address + 1.
- R9: A relative jump has bits 15..12 = 1111 and bit 0 = 0. If its condition holds, the next address is the current address plus the sign-extended bits 11..4; otherwise it is the current address + 1.
- R10: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Holds all state when high |
| instr_word | input | 16 | Instruction word at the fetch address |
| param_word | input | 16 | Word following the instruction word |
| flag_z | input | 1 | Zero flag |
| flag_le | input | 1 | Less-or-equal flag |
| fetch_addr | output | 16 | Address of the current instruction word |
| param_used | output | 1 | Current instruction consumes the parameter word |

## Verification
The hardest cases to reach from the ports are wrap-around and the return register. For wrap-around, an absolute jump first places the fetch address near 0xFFFF. From there a step, a two-word skip or a relative jump carries it across zero. The return register can only be observed through a later return. So each call is followed by unrelated instructions, stalls and a second, nested call, and then by a return whose target shows which value survived.

// File: rtl/branch_seq_pkg.sv
// Package: shared encodings for the branch sequencer.
// Assumes 16-bit instruction words; condition field in bits 3..1.
package branch_seq_pkg;
    typedef enum logic [2:0] {
        KIND_STEP,   // single-word, no control transfer
        KIND_WIDE,   // two-word, no control transfer
        KIND_ABS,    // absolute jump or call, two words
        KIND_RET,    // return through the link register
        KIND_REL     // signed 8-bit relative jump
    } word_kind_e;

    localparam logic [2:0] CC_LE  = 3'b001;
    localparam logic [2:0] CC_NZ  = 3'b100;
    localparam logic [2:0] CC_Z   = 3'b101;
    localparam logic [2:0] CC_ALL = 3'b111;
endpackage

// File: rtl/branch_seq_decode.sv
// Module: classifies an instruction word for the sequencer.
// Assumes the opcode layout of a 16-bit word; only bit patterns matter,
// no state is kept.
module branch_seq_decode
    import branch_seq_pkg::*;
#(
    parameter int IW    = 16,
    parameter int OFF_W = 8
) (
    input  logic [IW-1:0]    word_i,
    output word_kind_e       kind_o,
    output logic             link_o,
    output logic [2:0]       cc_o,
    output logic [OFF_W-1:0] disp_o
);
    localparam int DISP_LSB = 4;

    // Split the fixed fields out of the word.
    always_comb begin
        cc_o   = word_i[3:1];
        link_o = word_i[4];
        disp_o = word_i[DISP_LSB +: OFF_W];
    end

    // Choose the instruction class from the opcode prefixes.
    always_comb begin
        kind_o = KIND_STEP;
        if (word_i[15:12] == 4'hF && !word_i[0])
            kind_o = KIND_REL;
        else if (word_i[15:4] == 12'hE42 && !word_i[0])
            kind_o = KIND_RET;
        else if (word_i[15:6] == 10'b1110010000 && !word_i[5] && !word_i[0])
            kind_o = KIND_ABS;
        else if (word_i[15:6] == 10'b1110000000)
            kind_o = KIND_WIDE;
        else if (word_i[15:2] == 14'b11100000110000)
            kind_o = KIND_WIDE;
    end
endmodule

// File: rtl/branch_seq_cond.sv
// Module: evaluates a 3-bit condition code against the flags.
// Assumes undefined codes never hold.
module branch_seq_cond
    import branch_seq_pkg::*;
(
    input  logic [2:0] cc_i,
    input  logic       z_i,
    input  logic       le_i,
    output logic       hold_o
);
    // Map each defined code to its flag test.
    always_comb begin
        unique case (cc_i)
            CC_LE:   hold_o = le_i;
            CC_NZ:   hold_o = !z_i;
            CC_Z:    hold_o = z_i;
            CC_ALL:  hold_o = 1'b1;
            default: hold_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_seq_next.sv
// Module: computes the next fetch address and link-register update.
// Assumes AW <= IW so the parameter word can carry a full address.
module branch_seq_next
    import branch_seq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int IW    = 16,
    parameter int OFF_W = 8
) (
    input  logic [AW-1:0]    pc_i,
    input  logic [AW-1:0]    link_i,
    input  logic [IW-1:0]    param_i,
    input  word_kind_e       kind_i,
    input  logic             call_i,
    input  logic             take_i,
    input  logic [OFF_W-1:0] disp_i,
    output logic [AW-1:0]    pc_n_o,
    output logic             link_we_o,
    output logic [AW-1:0]    link_n_o
);
    localparam int EXT_W = AW - OFF_W;

    logic [AW-1:0] pc_p1;
    logic [AW-1:0] pc_p2;
    logic [AW-1:0] disp_ext;

    // Form the fall-through and displacement candidates.
    always_comb begin
        pc_p1    = pc_i + AW'(1);
        pc_p2    = pc_i + AW'(2);
        disp_ext = {{EXT_W{disp_i[OFF_W-1]}}, disp_i};
    end

    // Select the next address per class and condition.
    always_comb begin
        pc_n_o = pc_p1;
        unique case (kind_i)
            KIND_WIDE: pc_n_o = pc_p2;
            KIND_ABS:  pc_n_o = take_i ? param_i[AW-1:0] : pc_p2;
            KIND_RET:  pc_n_o = take_i ? link_i : pc_p1;
            KIND_REL:  pc_n_o = take_i ? (pc_i + disp_ext) : pc_p1;
            default:   pc_n_o = pc_p1;
        endcase
    end

    // Save the post-call address when a call is taken.
    always_comb begin
        link_we_o = (kind_i == KIND_ABS) && call_i && take_i;
        link_n_o  = pc_p2;
    end
endmodule

// File: rtl/branch_seq_top.sv
// Module: program counter sequencer with one link register.
// Assumes instr_word/param_word are the words at fetch_addr and
// fetch_addr+1 in the same cycle; synchronous active-low reset.
module branch_seq_top
    import branch_seq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int IW    = 16,
    parameter int OFF_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic [IW-1:0] instr_word,
    input  logic [IW-1:0] param_word,
    input  logic          flag_z,
    input  logic          flag_le,
    output logic [AW-1:0] fetch_addr,
    output logic          param_used
);
    word_kind_e       kind;
    logic             is_call;
    logic [2:0]       cc;
    logic [OFF_W-1:0] disp;
    logic             taken;
    logic [AW-1:0]    pc_q, pc_n;
    logic [AW-1:0]    ra_q, ra_n;
    logic             ra_we;

    branch_seq_decode #(.IW(IW), .OFF_W(OFF_W)) dec_i (
        .word_i(instr_word), .kind_o(kind), .link_o(is_call),
        .cc_o(cc), .disp_o(disp)
    );

    branch_seq_cond cond_i (
        .cc_i(cc), .z_i(flag_z), .le_i(flag_le), .hold_o(taken)
    );

    branch_seq_next #(.AW(AW), .IW(IW), .OFF_W(OFF_W)) next_i (
        .pc_i(pc_q), .link_i(ra_q), .param_i(param_word),
        .kind_i(kind), .call_i(is_call), .take_i(taken), .disp_i(disp),
        .pc_n_o(pc_n), .link_we_o(ra_we), .link_n_o(ra_n)
    );

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (!stall) pc_q <= pc_n;
    end

    // Single-level return register.
    always_ff @(posedge clk) begin
        if (!rst_n)              ra_q <= '0;
        else if (!stall && ra_we) ra_q <= ra_n;
    end

    // Drive outputs.
    always_comb begin
        fetch_addr = pc_q;
        param_used = (kind == KIND_WIDE) || (kind == KIND_ABS);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && ra_q == '0)); // R1
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(pc_q) && $stable(ra_q))); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && kind == KIND_STEP) |=> pc_q == $past(pc_q) + AW'(1)); // R3
    AST_SKIP_PARAM: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && param_used && !(kind == KIND_ABS && taken))
        |=> pc_q == $past(pc_q) + AW'(2)); // R4
    AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && kind == KIND_ABS && is_call && taken)
        |=> ra_q == $past(pc_q) + AW'(2)); // R7
    AST_LINK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(kind == KIND_ABS && is_call && taken) |=> $stable(ra_q)); // R7
    AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && kind == KIND_RET && taken) |=> pc_q == $past(ra_q)); // R8
endmodule

// File: tb/branch_seq_top_tb.sv
// Directed bench for branch_seq_top; reference model written from the
// requirements in the brief.
module branch_seq_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall;
    logic [15:0] instr_word;
    logic [15:0] param_word;
    logic        flag_z;
    logic        flag_le;
    logic [15:0] fetch_addr;
    logic        param_used;

    int tests  = 0;
    int fails  = 0;
    bit closed = 0;
    logic [15:0] exp_pc;
    logic [15:0] exp_ra;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .instr_word(instr_word), .param_word(param_word),
        .flag_z(flag_z), .flag_le(flag_le),
        .fetch_addr(fetch_addr), .param_used(param_used)
    );

    localparam logic [15:0] NOP = 16'hE190;

    function automatic logic [15:0] abs_w(input bit lnk, input logic [2:0] c);
        return {10'b1110010000, 1'b0, lnk, c, 1'b0};
    endfunction
    function automatic logic [15:0] ret_w(input logic [2:0] c);
        return {12'hE42, c, 1'b0};
    endfunction
    function automatic logic [15:0] rel_w(input logic [7:0] off, input logic [2:0] c);
        return {4'hF, off, c, 1'b0};
    endfunction

    function automatic bit cond_ok(input logic [2:0] c, input logic z, input logic le);
        case (c)
            3'b001:  return le;
            3'b100:  return !z;
            3'b101:  return z;
            3'b111:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One instruction: drive, check param_used, clock, check address.
    task automatic step(input logic [15:0] i, input logic [15:0] p, input logic z,
                        input logic le, input logic st, input string req);
        bit is_abs, is_ret, is_rel, wide, tk;
        logic [15:0] npc;
        @(negedge clk);
        instr_word = i; param_word = p; flag_z = z; flag_le = le; stall = st;
        is_abs = (i[15:6] == 10'b1110010000) && !i[5] && !i[0];
        is_ret = (i[15:4] == 12'hE42) && !i[0];
        is_rel = (i[15:12] == 4'hF) && !i[0];
        wide   = (i[15:6] == 10'b1110000000) || (i[15:2] == 14'b11100000110000);
        tk     = cond_ok(i[3:1], z, le);
        #1;
        check({req, " param_used"}, {15'd0, param_used}, {15'd0, is_abs | wide});
        npc = exp_pc + 16'd1;
        if (wide) npc = exp_pc + 16'd2;
        if (is_abs) npc = tk ? p : exp_pc + 16'd2;
        if (is_ret && tk) npc = exp_ra;
        if (is_rel && tk) npc = exp_pc + {{8{i[11]}}, i[11:4]};
        if (!st) begin
            if (is_abs && i[4] && tk) exp_ra = exp_pc + 16'd2;
            exp_pc = npc;
        end
        @(posedge clk); #1;
        check({req, " fetch_addr"}, fetch_addr, exp_pc);
    endtask

    task automatic goto(input logic [15:0] a);
        step(abs_w(0, 3'b111), a, 0, 0, 0, "R6 setup");
    endtask

    task automatic t_reset;
        rst_n = 0; stall = 0; instr_word = NOP; param_word = 0; flag_z = 0; flag_le = 0;
        repeat (3) @(posedge clk);
        #1;
        exp_pc = 0; exp_ra = 0;
        check("R1 pc after reset", fetch_addr, 16'h0000);
        @(negedge clk); rst_n = 1;
        step(ret_w(3'b111), 0, 0, 0, 0, "R1 ra after reset");
    endtask

    task automatic t_plain;
        step(NOP, 16'h1234, 0, 0, 0, "R3 nop");
        step(16'hA042, 16'hFFFF, 1, 1, 0, "R3 imm7");
        step(16'hE050, 16'h0, 0, 0, 0, "R3 binary");
        step(abs_w(0, 3'b111) | 16'h1, 16'h4000, 0, 0, 0, "R3 abs bit0 set");
        step(rel_w(8'h10, 3'b111) | 16'h1, 0, 0, 0, 0, "R3 rel bit0 set");
    endtask

    task automatic t_wide;
        step(16'hE004, 16'h5555, 0, 0, 0, "R4 imm16");
        step(16'hE0C1, 16'h0100, 0, 0, 0, "R4 load");
        step(16'hE0C3, 16'h0100, 0, 0, 0, "R4 store");
    endtask

    task automatic t_conds;
        for (int c = 0; c < 8; c++)
            for (int f = 0; f < 4; f++) begin
                goto(16'h0200);
                step(abs_w(0, c[2:0]), 16'h0300, f[0], f[1], 0, "R5 cond");
            end
    endtask

    task automatic t_abs;
        goto(16'h1000);
        step(abs_w(0, 3'b101), 16'h2000, 1, 0, 0, "R6 jumpz taken");
        step(abs_w(0, 3'b101), 16'h3000, 0, 0, 0, "R6 jumpz fall");
        step(abs_w(0, 3'b001), 16'h4000, 0, 1, 0, "R6 jumple taken");
    endtask

    task automatic t_call_ret;
        goto(16'h0500);
        step(abs_w(1, 3'b111), 16'h0800, 0, 0, 0, "R7 call");
        step(abs_w(0, 3'b111), 16'h0900, 0, 0, 0, "R7 jump keeps link");
        step(abs_w(1, 3'b100), 16'h0A00, 1, 0, 0, "R7 callnz not taken");
        step(ret_w(3'b101), 0, 0, 0, 0, "R8 retz not taken");
        step(ret_w(3'b101), 0, 1, 0, 0, "R8 retz taken");
        check("R7 link value", exp_pc, 16'h0502);
        goto(16'h0600);
        step(abs_w(1, 3'b111), 16'h0700, 0, 0, 0, "R7 outer call");
        step(abs_w(1, 3'b001), 16'h0780, 0, 1, 0, "R7 nested call");
        step(ret_w(3'b111), 0, 0, 0, 0, "R8 ret after nesting");
        check("R7 nested overwrite", fetch_addr, 16'h0702);
    endtask

    task automatic t_rel;
        goto(16'h0100);
        step(rel_w(8'h20, 3'b111), 0, 0, 0, 0, "R9 forward");
        step(rel_w(8'hF0, 3'b111), 0, 0, 0, 0, "R9 backward");
        step(rel_w(8'h80, 3'b100), 0, 0, 0, 0, "R9 most negative");
        step(rel_w(8'h7F, 3'b100), 0, 1, 0, 0, "R9 not taken");
        step(rel_w(8'h00, 3'b101), 0, 1, 0, 0, "R9 zero offset");
    endtask

    task automatic t_wrap;
        goto(16'hFFFF);
        step(NOP, 0, 0, 0, 0, "R10 step wrap");
        goto(16'hFFFE);
        step(16'hE004, 0, 0, 0, 0, "R10 wide wrap");
        goto(16'hFFF8);
        step(rel_w(8'h10, 3'b111), 0, 0, 0, 0, "R10 rel wrap");
        step(rel_w(8'hF0, 3'b111), 0, 0, 0, 0, "R10 rel back wrap");
        goto(16'hFFFF);
        step(abs_w(1, 3'b111), 16'h0010, 0, 0, 0, "R10 call link wrap");
        step(ret_w(3'b111), 0, 0, 0, 0, "R10 ret to wrapped link");
    endtask

    task automatic t_stall;
        goto(16'h0C00);
        step(abs_w(1, 3'b111), 16'h0D00, 0, 0, 0, "R2 prime link");
        step(abs_w(1, 3'b111), 16'h0E00, 0, 0, 1, "R2 stalled call");
        step(rel_w(8'h40, 3'b111), 0, 0, 0, 1, "R2 stalled rel");
        step(ret_w(3'b111), 0, 0, 0, 0, "R2 link held");
    endtask

    task automatic finish_run;
        if (!closed) begin
            closed = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_plain();
        t_wide();
        t_conds();
        t_abs();
        t_call_ret();
        t_rel();
        t_wrap();
        t_stall();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule